// File: doc/BRIEF.md
# Half-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two IEEE-754 binary16 values for one lane of a vector datapath. An operation select chooses between a + b and a − b, and a 2-bit rounding mode picks one of four rounding directions. The result is rounded exactly once from the infinitely precise sum. Three per-lane exception flags (invalid, overflow, inexact) leave the block for a sticky status register that lives elsewhere.

Both operands are mapped onto one wide fixed-point magnitude scale. On that scale every finite binary16 value, subnormals included, is an exact integer multiple of the smallest subnormal. The signed sum is therefore formed with no alignment loss, and a single normalize-and-round stage packs it back into binary16. Infinities, NaNs and signed zeros take priority paths ahead of that rounder. An optional output register stage adds one cycle of latency.

Top module: `f16_addsub`

## Requirements
- R1: With `sub_sel`=0 the result is a + b rounded once. Under mode 0 (nearest, ties to even), 0x6400 + 0x3800 gives 0x6400 and 0x6401 + 0x3800 gives 0x6402. A result word holds the sign in bit 15, the biased exponent (bias 15) in bits 14:10 and the fraction in bits 9:0.
- R2: `rnd_mode` selects the rounding: 0 = nearest-even, 1 = toward zero, 2 = toward +infinity, 3 = toward −infinity. 0x6400 + 0x3800 gives 0x6401 under mode 2 and 0x6400 under modes 1 and 3. 0xE400 + 0xB800 gives 0xE401 under mode 3.
- R3: With `sub_sel`=1 the result is a − b, formed by flipping the sign of b. When b is a NaN its sign is left untouched.
- R4: An exact zero sum of operands with opposite effective signs is +0 under modes 0, 1 and 2 and −0 under mode 3. Two zeros of the same effective sign keep that sign in every mode.
- R5: Adding infinities of opposite effective sign returns 0x7E00 with `flg_invalid`=1. Infinities of the same sign return that infinity with no flag.
- R6: If a is a NaN, its payload and sign are returned. Otherwise, if b is a NaN, b is returned. In both cases bit 9 of the result is forced to 1.
- R7: A signaling NaN input (exponent 31, bit 9 = 0, fraction nonzero) sets `flg_invalid`, even when the other operand is a quiet NaN. A merely inexact result leaves `flg_invalid` at 0.
- R8: On overflow, `flg_overflow` and `flg_inexact` are both set. The result is ±infinity under mode 0 and under the directed mode that rounds toward that infinity. Under every other mode it is ±0x7BFF.
- R9: Subnormal operands are added exactly. 0x03FF + 0x0001 gives 0x0400 and 0x0400 + 0x8001 gives 0x03FF, both with no flag. Any result with a zero exponent field has `flg_inexact`=0.
- R10: `flg_inexact` is set exactly when nonzero bits are discarded by rounding or on overflow. 0x3C00 + 0x0001 gives 0x3C00 under mode 0 and 0x3C01 under mode 2, both inexact.
- R11: With `OUT_REG`=1, the result and flags appear one clock after the inputs and hold until the next edge. While `rst_n` is low, all outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| opnd_a | input | 16 | First operand, binary16 |
| opnd_b | input | 16 | Second operand, binary16 |
| sub_sel | input | 1 | 0 = add, 1 = subtract b from a |
| rnd_mode | input | 2 | Rounding direction, encoded as in R2 |
| sum_o | output | 16 | Rounded binary16 result |
| flg_invalid | output | 1 | Invalid-operation flag for this lane |
| flg_overflow | output | 1 | Overflow flag for this lane |
| flg_inexact | output | 1 | Inexact flag for this lane |

## Verification
The assertions inspect only the packed result and the three flags, so they take for granted that every input word is a legal binary16 encoding. Because every 16-bit pattern is one, any input keeps them valid. They also assume that operands stay stable across a clock period, so that each sampled output belongs to a single operation; the stimulus changes the operands only on the falling edge. Operand generation is biased toward zeros, infinities, quiet and signaling NaNs, subnormals and top-binade values, and it pairs values with their near-negations to force cancellation, so that the exceptional paths are actually exercised.

// File: rtl/f16_pkg.sv
package f16_pkg;
    localparam int EXP_W  = 5;
    localparam int FRAC_W = 10;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int EXP_MAX = (1 << EXP_W) - 1;
    // largest finite operand: significand shifted by (EXP_MAX-2), plus one carry bit
    localparam int MAG_W  = SIG_W + (EXP_MAX - 2) + 1;
    localparam int LEAD_W = $clog2(MAG_W + 1);

    typedef struct packed {
        logic              sgn;
        logic [EXP_W-1:0]  expo;
        logic [FRAC_W-1:0] frac;
    } h16_t;

    typedef struct packed {
        logic             is_nan;
        logic             is_snan;
        logic             is_inf;
        logic             sgn;
        logic [MAG_W-1:0] mag;
    } h16_dec_t;

    typedef struct packed {
        h16_t res;
        logic nv;
        logic of;
        logic nx;
    } h16_out_t;
endpackage

// File: rtl/f16_unpack.sv
module f16_unpack
    import f16_pkg::*;
(
    input  logic [15:0] raw,
    input  logic        flip,
    output h16_dec_t    dec
);
    h16_t fld;
    logic [SIG_W-1:0] sig;
    logic [EXP_W-1:0] shamt;

    always_comb begin
        fld         = raw;
        dec.is_nan  = (fld.expo == EXP_W'(EXP_MAX)) && (fld.frac != '0);
        dec.is_snan = dec.is_nan && !fld.frac[FRAC_W-1];
        dec.is_inf  = (fld.expo == EXP_W'(EXP_MAX)) && (fld.frac == '0);
        dec.sgn     = fld.sgn ^ (flip && !dec.is_nan);
        sig         = {(fld.expo != '0), fld.frac};
        shamt       = (fld.expo == '0) ? '0 : fld.expo - 1'b1;
        dec.mag     = {{(MAG_W-SIG_W){1'b0}}, sig} << shamt;
    end
endmodule

// File: rtl/f16_round.sv
module f16_round
    import f16_pkg::*;
(
    input  logic             sgn,
    input  logic [MAG_W-1:0] mag,
    input  logic [1:0]       rm,
    output h16_out_t         rnd
);
    localparam logic [MAG_W-1:0] ONE = MAG_W'(1);

    logic [LEAD_W-1:0] lead;
    logic [LEAD_W-1:0] shamt;
    logic [MAG_W-1:0]  rem, half;
    logic [SIG_W-1:0]  keep;
    logic [SIG_W:0]    bumped;
    logic              guard, sticky, inc, to_inf;
    logic [EXP_W:0]    e_pre, e_fin;

    always_comb begin
        lead = '0;
        for (int i = 0; i < MAG_W; i++) begin
            if (mag[i]) lead = LEAD_W'(i);
        end
        shamt  = (lead > LEAD_W'(FRAC_W)) ? lead - LEAD_W'(FRAC_W) : '0;
        keep   = SIG_W'(mag >> shamt);
        rem    = mag & ((ONE << shamt) - ONE);
        half   = (shamt == '0) ? '0 : (ONE << (shamt - 1'b1));
        guard  = |(rem & half);
        sticky = |(rem & ~half);
        e_pre  = (lead >= LEAD_W'(FRAC_W)) ? (EXP_W+1)'(lead - LEAD_W'(FRAC_W - 1)) : '0;

        unique case (rm)
            2'd0:    inc = guard && (sticky || keep[0]);
            2'd1:    inc = 1'b0;
            2'd2:    inc = (guard || sticky) && !sgn;
            default: inc = (guard || sticky) && sgn;
        endcase

        bumped = {1'b0, keep} + (SIG_W+1)'(inc);
        e_fin  = bumped[SIG_W] ? e_pre + 1'b1 : e_pre;
        to_inf = (rm == 2'd0) || (rm == 2'd2 && !sgn) || (rm == 2'd3 && sgn);

        rnd = '0;
        rnd.res.sgn = sgn;
        if (e_fin >= (EXP_W+1)'(EXP_MAX)) begin
            rnd.of = 1'b1;
            rnd.nx = 1'b1;
            rnd.res.expo = to_inf ? EXP_W'(EXP_MAX) : EXP_W'(EXP_MAX - 1);
            rnd.res.frac = to_inf ? '0 : '1;
        end else begin
            rnd.nx = guard || sticky;
            rnd.res.expo = e_fin[EXP_W-1:0];
            rnd.res.frac = bumped[SIG_W] ? '0 : bumped[FRAC_W-1:0];
        end
    end
endmodule

// File: rtl/f16_addsub.sv
module f16_addsub
    import f16_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] opnd_a,
    input  logic [15:0] opnd_b,
    input  logic        sub_sel,
    input  logic [1:0]  rnd_mode,
    output logic [15:0] sum_o,
    output logic        flg_invalid,
    output logic        flg_overflow,
    output logic        flg_inexact
);
    localparam logic [FRAC_W-1:0] QUIET_BIT = FRAC_W'(1) << (FRAC_W - 1);

    h16_dec_t         dec_a, dec_b;
    logic [MAG_W-1:0] mag_sum;
    logic             sgn_sum;
    h16_out_t         rnd_out;
    h16_out_t         nxt_d, out_q;
    h16_t             raw_a, raw_b;

    f16_unpack u_unp_a (.raw(opnd_a), .flip(1'b0),    .dec(dec_a));
    f16_unpack u_unp_b (.raw(opnd_b), .flip(sub_sel), .dec(dec_b));

    // exact signed-magnitude sum on the common fixed-point scale
    always_comb begin
        if (dec_a.sgn == dec_b.sgn) begin
            mag_sum = dec_a.mag + dec_b.mag;
            sgn_sum = dec_a.sgn;
        end else if (dec_a.mag >= dec_b.mag) begin
            mag_sum = dec_a.mag - dec_b.mag;
            sgn_sum = dec_a.sgn;
        end else begin
            mag_sum = dec_b.mag - dec_a.mag;
            sgn_sum = dec_b.sgn;
        end
    end

    f16_round u_round (.sgn(sgn_sum), .mag(mag_sum), .rm(rnd_mode), .rnd(rnd_out));

    // special-value priority ahead of the rounded path
    always_comb begin
        raw_a = opnd_a;
        raw_b = opnd_b;
        nxt_d = '0;
        if (dec_a.is_nan) begin
            nxt_d.res = raw_a;
            nxt_d.res.frac = raw_a.frac | QUIET_BIT;
            nxt_d.nv = dec_a.is_snan || dec_b.is_snan;
        end else if (dec_b.is_nan) begin
            nxt_d.res = raw_b;
            nxt_d.res.frac = raw_b.frac | QUIET_BIT;
            nxt_d.nv = dec_b.is_snan;
        end else if (dec_a.is_inf && dec_b.is_inf && (dec_a.sgn != dec_b.sgn)) begin
            nxt_d.res = '{sgn: 1'b0, expo: EXP_W'(EXP_MAX), frac: QUIET_BIT};
            nxt_d.nv = 1'b1;
        end else if (dec_a.is_inf || dec_b.is_inf) begin
            nxt_d.res.sgn  = dec_a.is_inf ? dec_a.sgn : dec_b.sgn;
            nxt_d.res.expo = EXP_W'(EXP_MAX);
        end else if (mag_sum == '0) begin
            nxt_d.res.sgn = (dec_a.sgn == dec_b.sgn) ? dec_a.sgn : (rnd_mode == 2'd3);
        end else begin
            nxt_d = rnd_out;
        end
    end

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) out_q <= '0;
                else        out_q <= nxt_d;
            end
        end else begin : g_comb
            always_comb out_q = nxt_d;
        end
    endgenerate

    assign sum_o        = out_q.res;
    assign flg_invalid  = out_q.nv;
    assign flg_overflow = out_q.of;
    assign flg_inexact  = out_q.nx;

    logic out_is_nan;
    assign out_is_nan = (sum_o[14:10] == 5'h1F) && (sum_o[9:0] != '0);

    p_ovf_inexact_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flg_overflow |-> flg_inexact);
    p_ovf_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flg_overflow |-> (sum_o[14:0] == 15'h7C00 || sum_o[14:0] == 15'h7BFF));
    p_nan_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_is_nan |-> sum_o[9]);
    p_invalid_nan_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flg_invalid |-> out_is_nan);
    p_subn_exact_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_o[14:10] == 5'h00) |-> !flg_inexact);
    p_nan_no_round_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_is_nan |-> (!flg_inexact && !flg_overflow));
endmodule

// File: tb/f16_addsub_tb.sv
module f16_addsub_tb;
    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] opnd_a = '0, opnd_b = '0;
    logic        sub_sel = 1'b0;
    logic [1:0]  rnd_mode = '0;
    logic [15:0] sum_o;
    logic        flg_invalid, flg_overflow, flg_inexact;
    int n_tests = 0;
    int n_fail  = 0;

    always #HALF clk = ~clk;

    f16_addsub #(.OUT_REG(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .sub_sel(sub_sel), .rnd_mode(rnd_mode), .sum_o(sum_o),
        .flg_invalid(flg_invalid), .flg_overflow(flg_overflow), .flg_inexact(flg_inexact));

    function automatic logic [18:0] got_word();
        return {sum_o, flg_invalid, flg_overflow, flg_inexact};
    endfunction

    function automatic longint unsigned mag_of(input logic [15:0] v);
        longint unsigned m;
        m = (v[14:10] == 0) ? longint'(v[9:0]) : longint'({1'b1, v[9:0]});
        if (v[14:10] > 1) m = m << (v[14:10] - 1);
        return m;
    endfunction

    // behavioural reference: {result, invalid, overflow, inexact}
    function automatic logic [18:0] ref_model(input logic [15:0] a, input logic [15:0] b,
                                               input logic op, input logic [1:0] rm);
        bit an, bn, as_, bs_, ai, bi, sa, sb, sg, g, st, inc, lsb;
        longint sum, m;
        int e;
        logic [15:0] r;
        an  = (a[14:10] == 31) && (a[9:0] != 0);
        bn  = (b[14:10] == 31) && (b[9:0] != 0);
        as_ = an && !a[9];
        bs_ = bn && !b[9];
        ai  = (a[14:10] == 31) && (a[9:0] == 0);
        bi  = (b[14:10] == 31) && (b[9:0] == 0);
        sa  = a[15];
        sb  = b[15] ^ op;
        if (an) return {a | 16'h0200, as_ | bs_, 2'b00};
        if (bn) return {b | 16'h0200, bs_, 2'b00};
        if (ai && bi && sa != sb) return {16'h7E00, 3'b100};
        if (ai) return {sa, 15'h7C00, 3'b000};
        if (bi) return {sb, 15'h7C00, 3'b000};
        sum = (sa ? -longint'(mag_of(a)) : longint'(mag_of(a)))
            + (sb ? -longint'(mag_of(b)) : longint'(mag_of(b)));
        if (sum == 0) return {((sa == sb) ? sa : (rm == 2'd3)), 15'h0, 3'b000};
        sg = sum < 0;
        m  = sg ? -sum : sum;
        e  = 1; g = 0; st = 0;
        while (m >= 2048) begin
            st = st | g;
            g  = m[0];
            m  = m >> 1;
            e++;
        end
        lsb = m[0];
        case (rm)
            2'd0: inc = g && (st || lsb);
            2'd1: inc = 0;
            2'd2: inc = (g || st) && !sg;
            default: inc = (g || st) && sg;
        endcase
        m = m + inc;
        if (m == 2048) begin m = 1024; e++; end
        if (e >= 31) begin
            if (rm == 0 || (rm == 2 && !sg) || (rm == 3 && sg)) r = {sg, 15'h7C00};
            else r = {sg, 15'h7BFF};
            return {r, 3'b011};
        end
        r = {sg, (m >= 1024) ? 5'(e) : 5'd0, m[9:0]};
        return {r, 1'b0, 1'b0, (g || st)};
    endfunction

    task automatic check(input string tag, input logic [18:0] act, input logic [18:0] exp_w,
                         input logic [15:0] a, input logic [15:0] b, input logic op,
                         input logic [1:0] rm);
        n_tests++;
        if (act !== exp_w) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h sub=%0d rm=%0d actual=%h expected=%h",
                     tag, a, b, op, rm, act, exp_w);
        end
    endtask

    // drive on falling edge, sample one registered cycle later away from the edge
    task automatic run_vec(input logic [15:0] a, input logic [15:0] b, input logic op,
                           input logic [1:0] rm, input logic [18:0] exp_w, input string tag);
        @(negedge clk);
        opnd_a = a; opnd_b = b; sub_sel = op; rnd_mode = rm;
        @(posedge clk);
        #1;
        check(tag, got_word(), exp_w, a, b, op, rm);
    endtask

    task automatic run_ref(input logic [15:0] a, input logic [15:0] b, input logic op,
                           input logic [1:0] rm, input string tag);
        run_vec(a, b, op, rm, ref_model(a, b, op, rm), tag);
    endtask

    function automatic logic [15:0] pick_operand();
        logic [15:0] v;
        v = 16'($urandom);
        case ($urandom % 8)
            0: v[14:0] = '0;
            1: v[14:0] = 15'h7C00;
            2: v[14:9] = 6'b111111;
            3: begin v[14:9] = 6'b111110; v[8:0] = 9'($urandom % 511 + 1); end
            4: v[14:10] = 5'd0;
            5: v[14:10] = 5'd30;
            default: ;
        endcase
        return v;
    endfunction

    initial begin
        #(2 * HALF * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [18:0] held;
        repeat (3) @(posedge clk);
        #1;
        check("R11", got_word(), 19'h0, opnd_a, opnd_b, sub_sel, rnd_mode); // reset clears outputs
        @(negedge clk);
        rst_n = 1'b1;

        // R1 nearest-even ties
        run_vec(16'h6400, 16'h3800, 0, 0, {16'h6400, 3'b001}, "R1");
        run_vec(16'h6401, 16'h3800, 0, 0, {16'h6402, 3'b001}, "R1");
        run_vec(16'h3C00, 16'h3C00, 0, 0, {16'h4000, 3'b000}, "R1");
        // R2 directed modes
        run_vec(16'h6400, 16'h3800, 0, 2, {16'h6401, 3'b001}, "R2");
        run_vec(16'h6400, 16'h3800, 0, 1, {16'h6400, 3'b001}, "R2");
        run_vec(16'h6400, 16'h3800, 0, 3, {16'h6400, 3'b001}, "R2");
        run_vec(16'hE400, 16'hB800, 0, 3, {16'hE401, 3'b001}, "R2");
        run_vec(16'hE400, 16'hB800, 0, 2, {16'hE400, 3'b001}, "R2");
        // R3 subtract, NaN b keeps its sign
        run_vec(16'h4200, 16'h3C00, 1, 0, {16'h4000, 3'b000}, "R3");
        run_vec(16'h4200, 16'h7E55, 1, 0, {16'h7E55, 3'b000}, "R3");
        run_vec(16'h4200, 16'hFE55, 1, 0, {16'hFE55, 3'b000}, "R3");
        // R4 signed zeros
        run_vec(16'h0000, 16'h8000, 0, 0, {16'h0000, 3'b000}, "R4");
        run_vec(16'h0000, 16'h8000, 0, 3, {16'h8000, 3'b000}, "R4");
        run_vec(16'h4000, 16'hC000, 0, 0, {16'h0000, 3'b000}, "R4");
        run_vec(16'h4000, 16'hC000, 0, 3, {16'h8000, 3'b000}, "R4");
        run_vec(16'h8000, 16'h8000, 0, 2, {16'h8000, 3'b000}, "R4");
        run_vec(16'h4000, 16'h4000, 1, 3, {16'h8000, 3'b000}, "R4");
        // R5 infinities
        run_vec(16'h7C00, 16'hFC00, 0, 0, {16'h7E00, 3'b100}, "R5");
        run_vec(16'h7C00, 16'h7C00, 1, 0, {16'h7E00, 3'b100}, "R5");
        run_vec(16'h7C00, 16'h7C00, 0, 0, {16'h7C00, 3'b000}, "R5");
        // R6 NaN precedence and quieting
        run_vec(16'h7E11, 16'h7E55, 0, 0, {16'h7E11, 3'b000}, "R6");
        run_vec(16'h7D11, 16'h4200, 0, 0, {16'h7F11, 3'b100}, "R6");
        run_vec(16'h4200, 16'h7D55, 0, 0, {16'h7F55, 3'b100}, "R6");
        run_vec(16'hFE11, 16'h7E55, 1, 0, {16'hFE11, 3'b000}, "R6");
        // R7 signaling input raises invalid; inexact alone does not
        run_vec(16'h7E11, 16'h7D55, 0, 0, {16'h7E11, 3'b100}, "R7");
        run_vec(16'h6401, 16'h3800, 0, 1, {16'h6401, 3'b001}, "R7");
        // R8 overflow per mode
        run_vec(16'h7BFF, 16'h7BFF, 0, 0, {16'h7C00, 3'b011}, "R8");
        run_vec(16'h7BFF, 16'h7BFF, 0, 1, {16'h7BFF, 3'b011}, "R8");
        run_vec(16'h7BFF, 16'h7BFF, 0, 2, {16'h7C00, 3'b011}, "R8");
        run_vec(16'h7BFF, 16'h7BFF, 0, 3, {16'h7BFF, 3'b011}, "R8");
        run_vec(16'hFBFF, 16'hFBFF, 0, 2, {16'hFBFF, 3'b011}, "R8");
        run_vec(16'hFBFF, 16'hFBFF, 0, 3, {16'hFC00, 3'b011}, "R8");
        // R9 subnormals
        run_vec(16'h0001, 16'h0001, 0, 0, {16'h0002, 3'b000}, "R9");
        run_vec(16'h03FF, 16'h0001, 0, 0, {16'h0400, 3'b000}, "R9");
        run_vec(16'h8001, 16'h0002, 0, 0, {16'h0001, 3'b000}, "R9");
        run_vec(16'h0400, 16'h8001, 0, 0, {16'h03FF, 3'b000}, "R9");
        // R10 inexact
        run_vec(16'h3C00, 16'h0001, 0, 0, {16'h3C00, 3'b001}, "R10");
        run_vec(16'h3C00, 16'h0001, 0, 2, {16'h3C01, 3'b001}, "R10");
        run_vec(16'h3C00, 16'h0001, 0, 3, {16'h3C00, 3'b001}, "R10");

        // R11 output holds until the next edge after new inputs
        held = got_word();
        @(negedge clk);
        opnd_a = 16'h4000; opnd_b = 16'h4000; sub_sel = 0; rnd_mode = 0;
        #1;
        check("R11", got_word(), held, opnd_a, opnd_b, sub_sel, rnd_mode);
        @(posedge clk);
        #1;
        check("R11", got_word(), {16'h4400, 3'b000}, opnd_a, opnd_b, sub_sel, rnd_mode);

        // mixed stimulus against the reference model
        for (int k = 0; k < 6000; k++) begin
            logic [15:0] a, b;
            logic op;
            a  = pick_operand();
            b  = (k % 5 == 0) ? ({~a[15], a[14:0]} ^ 16'($urandom % 4)) : pick_operand();
            op = 1'($urandom);
            run_ref(a, b, op, 2'($urandom), op ? "R3" : "R1");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule